// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter Timer

A 32-bit down-counting timer that sits on a simple synchronous register bus. The counter is clocked by one of two enable strobes: a peripheral-rate strobe or a slow (about 32 kHz) strobe. A source-select field in the control word picks the strobe, and a 12-bit divider slows it further. Software sets up the control, load and compare words. It reads a live counter value and a sticky compare flag, and it gets a level interrupt when the flag is set and both the interrupt and the timer are enabled.

In wrap mode the counter runs down to zero and then continues from all ones. In reload mode it restarts from the load word each time it passes zero. A load-word write can force the counter to the new value at once, or it can leave the new value to take effect at the next reload. A soft-reset bit in the control word brings the timer back to a known state. It keeps the enable, enable-mode and four power/debug enable bits, which are only stored.

Top module: `pit_timer`

## Requirements
- R1: Registers are selected by byte address: 0x00 control, 0x04 status (flag in bit 0), 0x08 load, 0x0C compare, 0x10 counter (read-only). Any other address reads zero. After reset, control, status, load and compare read zero and the counter reads 0xFFFFFFFF.
- R2: A control write stores the written value with bits 31..26 forced to zero. Bit 16 (soft reset) is never stored. Control bit layout: 0 enable, 1 enable-mode, 2 compare interrupt enable, 3 reload mode, 15..4 divider, 16 soft reset, 17 overwrite, 18..21 stored-only enables, 25..24 source select.
- R3: While enabled, the counter steps once for every (divider + 1) strobes of the selected source. Source 00 gives no strobes, 01 and 10 use the peripheral strobe, and 11 uses the slow strobe. The divider phase restarts on an enable rise and on a soft reset.
- R4: A control write with bit 16 set keeps only bits 0, 1 and 18..21 of the written value and clears the status flag. It also sets the counter to 0xFFFFFFFF. If enable stays set, the timer keeps counting once a source is selected again.
- R5: irq_o is high exactly when the status flag, the compare interrupt enable bit and the enable bit are all set.
- R6: Writing 1 to status bit 0 clears the flag, and writing 0 has no effect. If a clear write and a flag set fall in the same cycle, the flag ends up set.
- R7: The flag sets on the counter step that brings the counter to the compare value. It then stays set until it is cleared.
- R8: When enable goes from 0 to 1 with enable-mode set, the counter starts from the load word if reload mode is set, and from 0xFFFFFFFF otherwise. Without enable-mode the counter keeps its value.
- R9: With enable clear, the counter holds its value whatever strobes arrive.
- R10: A step from zero goes to the load word in reload mode and to 0xFFFFFFFF in wrap mode.
- R11: A load-word write with the overwrite bit set puts the written value into the counter in the next cycle. Without that bit the counter is untouched, and the new word is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| per_stb_i | input | 1 | Peripheral-rate source strobe |
| slow_stb_i | input | 1 | Slow source strobe |
| bus_we_i | input | 1 | Register write enable |
| bus_addr_i | input | 5 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Level interrupt |

## Verification
Each register write, and each selected strobe that completes a divider period, takes effect at the clock edge that samples it. The register value, counter, flag and interrupt are therefore due one edge later. Read data follows the address combinationally within the same cycle. The bench drives every write and strobe for exactly one edge and reads on the following falling edge. It sweeps the source code, the divider value and the strobe count, and it computes the expected count arithmetically.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int DW        = 32;
    localparam int PSC_W     = 12;
    localparam int SRC_W     = 2;

    // control bit positions
    localparam int CB_EN     = 0;
    localparam int CB_EMOD   = 1;
    localparam int CB_CIE    = 2;
    localparam int CB_RLD    = 3;
    localparam int CB_PSC    = 4;
    localparam int CB_SRST   = 16;
    localparam int CB_OVW    = 17;
    localparam int CB_SRC    = 24;

    localparam logic [DW-1:0] CTRL_MASK = 32'h03FF_FFFF;
    localparam logic [DW-1:0] KEEP_MASK = 32'h003C_0003;

    // word indices
    localparam logic [2:0] RI_CTRL = 3'd0;
    localparam logic [2:0] RI_STAT = 3'd1;
    localparam logic [2:0] RI_LOAD = 3'd2;
    localparam logic [2:0] RI_CMP  = 3'd3;
    localparam logic [2:0] RI_CNT  = 3'd4;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic          flag;
        logic [DW-1:0] load;
        logic [DW-1:0] cmp;
    } regs_t;

endpackage

// File: rtl/ptmr_tick_gen.sv
module ptmr_tick_gen #(
    parameter int PSC_W = 12,
    parameter int SRC_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [SRC_W-1:0] src_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic             per_stb_i,
    input  logic             slow_stb_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PSC_W-1:0] phase;
    } st_t;

    st_t st_d, st_q;
    logic sel_stb;
    logic wrap;

    always_comb begin
        unique case (src_i)
            2'b01, 2'b10: sel_stb = per_stb_i;
            2'b11:        sel_stb = slow_stb_i;
            default:      sel_stb = 1'b0;
        endcase
        wrap   = (st_q.phase >= psc_i);
        tick_o = en_i && sel_stb && !clr_i && wrap;
        st_d   = st_q;
        if (clr_i) begin
            st_d.phase = '0;
        end else if (en_i && sel_stb) begin
            st_d.phase = wrap ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/ptmr_down_counter.sv
module ptmr_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             force_i,
    input  logic [CNT_W-1:0] force_val_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] stepped;

    always_comb begin
        if (st_q.cnt == '0) stepped = reload_i ? load_i : '1;
        else                stepped = st_q.cnt - 1'b1;

        st_d  = st_q;
        hit_o = 1'b0;
        if (force_i) begin
            st_d.cnt = force_val_i;
        end else if (en_i && tick_i) begin
            st_d.cnt = stepped;
            hit_o    = (stepped == cmp_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q.cnt <= '1;
        else         st_q     <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import ptmr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              per_stb_i,
    input  logic              slow_stb_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              irq_o
);

    localparam int IDX_W = ADDR_W - 2;

    regs_t st_d, st_q;

    logic [IDX_W-1:0] idx;
    logic wr_ctrl, wr_stat, wr_load, wr_cmp;
    logic srst, en_rise;
    logic cnt_force;
    logic [DW-1:0] cnt_force_val;
    logic [DW-1:0] cnt_w;
    logic tick_w, hit_w;
    logic [DW-1:0] ctrl_w;
    logic flag_w;

    assign idx = bus_addr_i[ADDR_W-1:2];

    always_comb begin
        wr_ctrl = bus_we_i && (idx == IDX_W'(RI_CTRL));
        wr_stat = bus_we_i && (idx == IDX_W'(RI_STAT));
        wr_load = bus_we_i && (idx == IDX_W'(RI_LOAD));
        wr_cmp  = bus_we_i && (idx == IDX_W'(RI_CMP));
        srst    = wr_ctrl && bus_wdata_i[CB_SRST];
        en_rise = wr_ctrl && !srst && bus_wdata_i[CB_EN] && !st_q.ctrl[CB_EN];

        cnt_force     = 1'b0;
        cnt_force_val = st_q.load;
        if (srst) begin
            cnt_force     = 1'b1;
            cnt_force_val = '1;
        end else if (en_rise && bus_wdata_i[CB_EMOD]) begin
            cnt_force     = 1'b1;
            cnt_force_val = bus_wdata_i[CB_RLD] ? st_q.load : '1;
        end else if (wr_load && st_q.ctrl[CB_OVW]) begin
            cnt_force     = 1'b1;
            cnt_force_val = bus_wdata_i;
        end

        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl = bus_wdata_i & CTRL_MASK;
            if (srst) st_d.ctrl = bus_wdata_i & KEEP_MASK;
        end
        if (wr_load) st_d.load = bus_wdata_i;
        if (wr_cmp)  st_d.cmp  = bus_wdata_i;

        if (wr_stat && bus_wdata_i[0]) st_d.flag = 1'b0;
        if (hit_w)                     st_d.flag = 1'b1;
        if (srst)                      st_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    ptmr_tick_gen #(
        .PSC_W (PSC_W),
        .SRC_W (SRC_W)
    ) u_tick (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (st_q.ctrl[CB_EN]),
        .clr_i      (srst || en_rise),
        .src_i      (st_q.ctrl[CB_SRC +: SRC_W]),
        .psc_i      (st_q.ctrl[CB_PSC +: PSC_W]),
        .per_stb_i  (per_stb_i),
        .slow_stb_i (slow_stb_i),
        .tick_o     (tick_w)
    );

    ptmr_down_counter #(
        .CNT_W (DW)
    ) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (st_q.ctrl[CB_EN]),
        .tick_i      (tick_w),
        .reload_i    (st_q.ctrl[CB_RLD]),
        .load_i      (st_q.load),
        .force_i     (cnt_force),
        .force_val_i (cnt_force_val),
        .cmp_i       (st_q.cmp),
        .cnt_o       (cnt_w),
        .hit_o       (hit_w)
    );

    always_comb begin
        unique case (idx)
            IDX_W'(RI_CTRL): bus_rdata_o = st_q.ctrl;
            IDX_W'(RI_STAT): bus_rdata_o = {{(DW-1){1'b0}}, st_q.flag};
            IDX_W'(RI_LOAD): bus_rdata_o = st_q.load;
            IDX_W'(RI_CMP):  bus_rdata_o = st_q.cmp;
            IDX_W'(RI_CNT):  bus_rdata_o = cnt_w;
            default:         bus_rdata_o = '0;
        endcase
    end

    assign irq_o  = st_q.flag && st_q.ctrl[CB_CIE] && st_q.ctrl[CB_EN];
    assign ctrl_w = st_q.ctrl;
    assign flag_w = st_q.flag;

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
    parameter int ADDR_W = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [31:0]       bus_wdata_i,
    input logic              irq_o,
    input logic [31:0]       ctrl,
    input logic              flag,
    input logic [31:0]       cnt,
    input logic              hit
);

    logic [ADDR_W-3:0] idx;
    logic wr_ctrl, wr_stat, wr_load;
    assign idx     = bus_addr_i[ADDR_W-1:2];
    assign wr_ctrl = bus_we_i && (idx == '0);
    assign wr_stat = bus_we_i && (idx == (ADDR_W-2)'(1));
    assign wr_load = bus_we_i && (idx == (ADDR_W-2)'(2));

    // R2
    ctrl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ctrl && !bus_wdata_i[16]) |=> (ctrl == ($past(bus_wdata_i) & 32'h03FF_FFFF)));

    // R4
    soft_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ctrl && bus_wdata_i[16]) |=> (cnt == 32'hFFFF_FFFF && !flag));

    // R5
    irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (flag && ctrl[0] && ctrl[2]));

    // R6
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_stat && bus_wdata_i[0] && !hit) |=> !flag);

    // R7
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag && !(wr_stat && bus_wdata_i[0]) && !(wr_ctrl && bus_wdata_i[16])) |=> flag);

    // R9
    frozen_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl[0] && !bus_we_i) |=> $stable(cnt));

    // R11
    overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_load && ctrl[17]) |=> (cnt == $past(bus_wdata_i)));

endmodule

bind pit_timer ptmr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .ctrl        (ctrl_w),
    .flag        (flag_w),
    .cnt         (cnt_w),
    .hit         (hit_w)
);

// File: tb/pit_timer_tb_top.sv
module pit_timer_tb_top;

    localparam int CLK_P = 10;

    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_STAT = 5'h04;
    localparam logic [4:0] A_LOAD = 5'h08;
    localparam logic [4:0] A_CMP  = 5'h0C;
    localparam logic [4:0] A_CNT  = 5'h10;

    localparam logic [31:0] EN   = 32'h1;
    localparam logic [31:0] EMOD = 32'h2;
    localparam logic [31:0] CIE  = 32'h4;
    localparam logic [31:0] RLD  = 32'h8;
    localparam logic [31:0] SRST = 32'h1_0000;
    localparam logic [31:0] OVW  = 32'h2_0000;
    localparam logic [31:0] SRC1 = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        per_stb = 1'b0;
    logic        slow_stb = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pit_timer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .per_stb_i   (per_stb),
        .slow_stb_i  (slow_stb),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v, input bit stb = 1'b0);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = v; per_stb = stb;
        @(posedge clk);
        #1 we = 1'b0; per_stb = 1'b0;
    endtask

    task automatic pulse(input bit slow, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (slow) slow_stb = 1'b1; else per_stb = 1'b1;
            @(posedge clk);
            #1 slow_stb = 1'b0; per_stb = 1'b0;
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic irq_chk(input string tag, input logic exp);
        @(negedge clk);
        #1 chk(tag, {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values and map
        rd_chk("R1 ctrl reset", A_CTRL, 32'h0);
        rd_chk("R1 stat reset", A_STAT, 32'h0);
        rd_chk("R1 load reset", A_LOAD, 32'h0);
        rd_chk("R1 cmp reset",  A_CMP,  32'h0);
        rd_chk("R1 cnt reset",  A_CNT,  32'hFFFF_FFFF);
        irq_chk("R5 irq reset", 1'b0);
        wr(A_CMP, 32'hA5A5_0F0F);
        rd_chk("R1 cmp readback", A_CMP, 32'hA5A5_0F0F);
        wr(A_LOAD, 32'h1234_5678);
        rd_chk("R1 load readback", A_LOAD, 32'h1234_5678);
        rd_chk("R11 load write without overwrite leaves count", A_CNT, 32'hFFFF_FFFF);
        rd_chk("R1 unmapped 0x14", 5'h14, 32'h0);
        rd_chk("R1 unmapped 0x1C", 5'h1C, 32'h0);

        // R2 control mask, soft-reset bit not stored
        wr(A_CTRL, 32'hFFFE_FFFE);
        rd_chk("R2 ctrl mask", A_CTRL, 32'h03FE_FFFE);
        wr(A_CTRL, 32'h0);

        // R3 sweep: source x divider x strobe count
        for (int src = 0; src < 4; src++) begin
            for (int psc = 0; psc < 4; psc++) begin
                for (int k = 0; k < 10; k++) begin
                    logic [31:0] cw;
                    int steps;
                    cw = EN | OVW | (32'(psc) << 4) | (32'(src) << 24);
                    wr(A_CTRL, 32'h0);
                    wr(A_CTRL, cw);
                    wr(A_LOAD, 32'd1000);
                    pulse(1'b0, k);
                    steps = (src == 1 || src == 2) ? k / (psc + 1) : 0;
                    rd_chk($sformatf("R3 per src%0d psc%0d k%0d", src, psc, k),
                           A_CNT, 32'd1000 - 32'(steps));
                end
            end
        end
        for (int psc = 0; psc < 4; psc++) begin
            for (int k = 0; k < 10; k++) begin
                wr(A_CTRL, 32'h0);
                wr(A_CTRL, EN | OVW | (32'(psc) << 4) | (32'd3 << 24));
                wr(A_LOAD, 32'd500);
                pulse(1'b1, k);
                rd_chk($sformatf("R3 slow psc%0d k%0d", psc, k), A_CNT, 32'd500 - 32'(k / (psc + 1)));
            end
        end

        // R10 wrap mode
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, EN | OVW | SRC1);
        wr(A_LOAD, 32'd2);
        pulse(1'b0, 4);
        rd_chk("R10 wrap to all ones", A_CNT, 32'hFFFF_FFFE);

        // R10 reload mode, R11 deferred load
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, EN | OVW | RLD | SRC1);
        wr(A_LOAD, 32'd5);
        pulse(1'b0, 7);
        rd_chk("R10 reload from load", A_CNT, 32'd4);
        wr(A_CTRL, EN | RLD | SRC1);
        wr(A_LOAD, 32'd9);
        rd_chk("R11 deferred load keeps count", A_CNT, 32'd4);
        pulse(1'b0, 5);
        rd_chk("R11 deferred load at reload", A_CNT, 32'd9);

        // R8 enable rise with enable-mode
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'd7);
        wr(A_CTRL, EN | EMOD | RLD | SRC1);
        rd_chk("R8 start from load", A_CNT, 32'd7);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, EN | EMOD | SRC1);
        rd_chk("R8 start from all ones", A_CNT, 32'hFFFF_FFFF);

        // R9 freeze and resume
        wr(A_CTRL, EN | OVW | SRC1);
        wr(A_LOAD, 32'd50);
        wr(A_CTRL, SRC1);
        pulse(1'b0, 3);
        rd_chk("R9 frozen when disabled", A_CNT, 32'd50);
        wr(A_CTRL, EN | SRC1);
        rd_chk("R8 no enable-mode keeps count", A_CNT, 32'd50);
        pulse(1'b0, 2);
        rd_chk("R9 resumes", A_CNT, 32'd48);

        // R7 / R5 / R6 compare flag and interrupt
        wr(A_CTRL, 32'h0);
        wr(A_CMP, 32'd3);
        wr(A_CTRL, EN | CIE | OVW | SRC1);
        wr(A_LOAD, 32'd5);
        pulse(1'b0, 1);
        rd_chk("R7 no flag before match", A_STAT, 32'h0);
        irq_chk("R5 irq low before match", 1'b0);
        pulse(1'b0, 1);
        rd_chk("R7 flag on match", A_STAT, 32'h1);
        irq_chk("R5 irq high", 1'b1);
        pulse(1'b0, 1);
        rd_chk("R7 flag sticky", A_STAT, 32'h1);
        wr(A_STAT, 32'h0);
        rd_chk("R6 write zero no effect", A_STAT, 32'h1);
        wr(A_CTRL, EN | OVW | SRC1);
        irq_chk("R5 irq gated by interrupt enable", 1'b0);
        rd_chk("R5 flag kept while gated", A_STAT, 32'h1);
        wr(A_CTRL, EN | CIE | OVW | SRC1);
        irq_chk("R5 irq back on", 1'b1);
        wr(A_STAT, 32'h1);
        rd_chk("R6 write one clears", A_STAT, 32'h0);
        irq_chk("R5 irq low after clear", 1'b0);
        wr(A_LOAD, 32'd4);
        wr(A_STAT, 32'h1, 1'b1);
        rd_chk("R6 set wins over clear", A_STAT, 32'h1);
        rd_chk("R7 count at match", A_CNT, 32'd3);
        wr(A_CTRL, CIE | OVW | SRC1);
        irq_chk("R5 irq gated by enable", 1'b0);
        wr(A_STAT, 32'h1);

        // R4 soft reset
        wr(A_CTRL, EN | CIE | OVW | SRC1);
        wr(A_LOAD, 32'd4);
        pulse(1'b0, 1);
        rd_chk("R4 flag set before soft reset", A_STAT, 32'h1);
        wr(A_CTRL, 32'h033F_FFFF);
        rd_chk("R4 ctrl kept bits", A_CTRL, 32'h003C_0003);
        rd_chk("R4 status cleared", A_STAT, 32'h0);
        rd_chk("R4 count all ones", A_CNT, 32'hFFFF_FFFF);
        rd_chk("R4 load kept", A_LOAD, 32'd4);
        pulse(1'b0, 2);
        rd_chk("R4 no source after reset", A_CNT, 32'hFFFF_FFFF);
        wr(A_CTRL, EN | SRC1);
        pulse(1'b0, 2);
        rd_chk("R4 still enabled, counting resumes", A_CNT, 32'hFFFF_FFFD);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule